// File: doc/BRIEF.md
# Two-Bit-Per-Step Successive-Approximation Controller

This block runs one conversion of a successive-approximation converter that settles two result bits in every approximation step. A start request opens a sampling phase. Four equal approximation steps follow, and then a single-cycle done pulse delivers the 8-bit code. The analog parts stay outside the block: the comparators, the resistor ladder, the sampling switches and the settling.

In each step the block drives two 7-bit tap indices to the ladder selector. One selects the lower reference and one selects the upper reference. Three comparators are used. The outer two compare the held input against those two references, and the middle one compares against the midpoint interpolated between them. Their three decisions come back as a thermometer code, qualified by a valid strobe. The block folds that code into one 2-bit digit. It then narrows the search window to a quarter of its previous width and places the next step's references from the digits already decided. In the last step the two references sit two codes apart, so a ladder of 128 taps gives 8-bit resolution.

Sampling length and step length are given as whole clock cycles. Their ratio sets how long the sampling phase lasts relative to one step.

Top module: `sar2_ctrl`

## Requirements
- R1: A start seen at a clock edge while idle raises `sampling` for SAMPLE_CYCLES cycles, starting in the next cycle. After that, `step_phase` bit k is high alone for STEP_CYCLES cycles, for k = 0, 1, 2, 3 in that order. `sampling` and `step_phase` are never high at the same time.
- R2: `tap_lo` and `tap_hi` are all zeros in every cycle in which no `step_phase` bit is high. This covers reset, idle and the sampling phase.
- R3: During step 0, the taps do not depend on any decided bit. `tap_lo` is 31 and `tap_hi` is 95, which correspond to thresholds 64 and 192.
- R4: During step k, let B be the value of the digits already decided, placed from the MSB down with lower bits zero, and let q = 64 >> (2k). Then `tap_lo` = (B+q-1)>>1 and `tap_hi` = (B+3q-1)>>1. `tap_hi` is always above `tap_lo`.
- R5: During the last step, `tap_hi` equals `tap_lo` + 1.
- R6: `cmp_therm` bit 0 is the lower comparator, bit 1 the middle one and bit 2 the upper one. Codes 000, 001, 011 and 111 give digits 0, 1, 2 and 3. The digit of step k lands in `result` bits [7-2k : 6-2k].
- R7: A code that is not a thermometer code (any higher bit set while a lower bit is clear) gives the digit equal to its number of ones. `code_err`, delivered with `done`, is 1 if this happened in any step of the conversion, and 0 otherwise.
- R8: `cmp_therm` is taken only in cycles of a step in which `cmp_valid` is high, and the last such cycle wins. A step with no valid cycle gives digit 0, whatever `cmp_therm` shows.
- R9: `done` is high for exactly one cycle, the cycle after the last cycle of step 3. `result` and `code_err` change only in that cycle and hold until the next `done`.
- R10: A start request made while a conversion is running has no effect on the phases or on the result.
- R11: While `rst_n` is low at a clock edge, the block returns to idle. `done`, `result`, `code_err`, `sampling`, `step_phase` and both taps all become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Conversion request, taken only while idle |
| cmp_valid | input | 1 | Qualifies `cmp_therm` in the current cycle |
| cmp_therm | input | 3 | Comparator decisions: bit 0 lower, bit 1 middle, bit 2 upper |
| sampling | output | 1 | High during the sampling phase |
| step_phase | output | 4 | One-hot strobe of the active approximation step |
| tap_lo | output | 7 | Lower reference tap index, zero outside steps |
| tap_hi | output | 7 | Upper reference tap index, zero outside steps |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | 8 | Converted code |
| code_err | output | 1 | A non-thermometer code was seen in the last conversion |

## Verification
The hardest situations to reach from the ports are the ones the comparators would never produce on their own:
- codes that are not thermometer codes,
- steps with no valid strobe while `cmp_therm` carries a misleading value,
- a second start request in the middle of a step.

The bench acts as the comparator array itself. It drives chosen codes on the first cycle of each step and holds `cmp_therm` at 111 in every cycle that is not qualified. It expects tap indices and results from the digits it has handed out, so every window position the drawn codes imply is reached directly. A reset in the middle of a step, after a conversion that left a nonzero result and a set error flag, shows that everything is cleared.

// File: rtl/sar2_pkg.sv
package sar2_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SAMPLE = 2'd1,
      PH_STEP   = 2'd2
   } sar2_phase_t;

   localparam int SAR2_DIG_W = 2;
   localparam int SAR2_CMP_N = (1 << SAR2_DIG_W) - 1;

endpackage

// File: rtl/sar2_therm_decode.sv
module sar2_therm_decode #(
   parameter int CMP_N = 3,
   parameter int DIG_W = 2
) (
   input  logic [CMP_N-1:0] therm,
   output logic [DIG_W-1:0] digit,
   output logic             bad
);

   if (CMP_N != (1 << DIG_W) - 1) begin : g_bad_cfg
      $error("sar2_therm_decode: comparator count must be 2**DIG_W-1");
   end

   // a higher comparator tripping while the one below it did not
   logic [CMP_N-2:0] gap;

   for (genvar i = 1; i < CMP_N; i++) begin : g_gap
      assign gap[i-1] = therm[i] & ~therm[i-1];
   end

   assign bad = |gap;

   always_comb begin
      digit = '0;
      for (int i = 0; i < CMP_N; i++) begin
         digit = digit + DIG_W'(therm[i]);
      end
   end

endmodule

// File: rtl/sar2_tap_calc.sv
module sar2_tap_calc #(
   parameter int RES_BITS = 8,
   parameter int STEP_W   = 2,
   parameter int TAP_W    = RES_BITS - 1
) (
   input  logic                en,
   input  logic [RES_BITS-1:0] base,
   input  logic [STEP_W-1:0]   step,
   output logic [TAP_W-1:0]    tap_lo,
   output logic [TAP_W-1:0]    tap_hi
);

   localparam int SUM_W = RES_BITS + 1;

   logic [SUM_W-1:0] quarter;
   logic [SUM_W-1:0] thr_lo;
   logic [SUM_W-1:0] thr_hi;
   logic [SUM_W-1:0] lo_m1;
   logic [SUM_W-1:0] hi_m1;

   always_comb begin
      quarter = (SUM_W'(1) << (RES_BITS - 2)) >> {step, 1'b0};
      thr_lo  = {1'b0, base} + quarter;
      thr_hi  = {1'b0, base} + quarter + (quarter << 1);
      lo_m1   = thr_lo - SUM_W'(1);
      hi_m1   = thr_hi - SUM_W'(1);
      tap_lo  = en ? TAP_W'(lo_m1 >> 1) : '0;
      tap_hi  = en ? TAP_W'(hi_m1 >> 1) : '0;
   end

endmodule

// File: rtl/sar2_seq.sv
module sar2_seq
   import sar2_pkg::*;
#(
   parameter int SAMPLE_CYCLES = 2,
   parameter int STEP_CYCLES   = 3,
   parameter int NUM_STEPS     = 4,
   parameter int STEP_W        = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              go,
   output logic              sampling,
   output logic              in_step,
   output logic [STEP_W-1:0] step_idx,
   output logic              step_last,
   output logic              conv_end
);

   localparam int LONGEST = (SAMPLE_CYCLES > STEP_CYCLES) ? SAMPLE_CYCLES : STEP_CYCLES;
   localparam int CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;

   if (SAMPLE_CYCLES < 1 || STEP_CYCLES < 1) begin : g_bad_len
      $error("sar2_seq: phase lengths must be at least one cycle");
   end

   sar2_phase_t      phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sample_end;

   assign go         = (phase_q == PH_IDLE) && start;
   assign sampling   = (phase_q == PH_SAMPLE);
   assign in_step    = (phase_q == PH_STEP);
   assign sample_end = sampling && (cnt_q == CNT_W'(SAMPLE_CYCLES - 1));
   assign step_last  = in_step && (cnt_q == CNT_W'(STEP_CYCLES - 1));
   assign conv_end   = step_last && (step_idx == STEP_W'(NUM_STEPS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         cnt_q    <= '0;
         step_idx <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               cnt_q    <= '0;
               step_idx <= '0;
               if (start) phase_q <= PH_SAMPLE;
            end
            PH_SAMPLE: begin
               if (sample_end) begin
                  phase_q <= PH_STEP;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            PH_STEP: begin
               if (step_last) begin
                  cnt_q <= '0;
                  if (conv_end) begin
                     phase_q  <= PH_IDLE;
                     step_idx <= '0;
                  end else begin
                     step_idx <= step_idx + STEP_W'(1);
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sar2_ctrl.sv
module sar2_ctrl
   import sar2_pkg::*;
#(
   parameter int RES_BITS      = 8,
   parameter int SAMPLE_CYCLES = 2,
   parameter int STEP_CYCLES   = 3,
   parameter int DIG_W         = SAR2_DIG_W,
   parameter int CMP_N         = SAR2_CMP_N,
   parameter int NUM_STEPS     = RES_BITS / DIG_W,
   parameter int TAP_W         = RES_BITS - 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 cmp_valid,
   input  logic [CMP_N-1:0]     cmp_therm,
   output logic                 sampling,
   output logic [NUM_STEPS-1:0] step_phase,
   output logic [TAP_W-1:0]     tap_lo,
   output logic [TAP_W-1:0]     tap_hi,
   output logic                 done,
   output logic [RES_BITS-1:0]  result,
   output logic                 code_err
);

   localparam int STEP_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;

   if (DIG_W != 2 || RES_BITS < 4 || (RES_BITS % DIG_W) != 0) begin : g_bad_res
      $error("sar2_ctrl: resolution must be an even count of at least four bits");
   end
   if (TAP_W != RES_BITS - 1) begin : g_bad_tap
      $error("sar2_ctrl: tap index must be one bit narrower than the result");
   end

   logic              go;
   logic              in_step;
   logic [STEP_W-1:0] step_idx;
   logic              step_last;
   logic              conv_end;

   sar2_seq #(
      .SAMPLE_CYCLES (SAMPLE_CYCLES),
      .STEP_CYCLES   (STEP_CYCLES),
      .NUM_STEPS     (NUM_STEPS),
      .STEP_W        (STEP_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .go        (go),
      .sampling  (sampling),
      .in_step   (in_step),
      .step_idx  (step_idx),
      .step_last (step_last),
      .conv_end  (conv_end)
   );

   for (genvar k = 0; k < NUM_STEPS; k++) begin : g_phase
      assign step_phase[k] = in_step && (step_idx == STEP_W'(k));
   end

   // comparator capture: last qualified code of the current step
   logic [CMP_N-1:0] cap_q;
   logic [CMP_N-1:0] code_use;
   logic [DIG_W-1:0] digit;
   logic             code_bad;

   assign code_use = cmp_valid ? cmp_therm : cap_q;

   sar2_therm_decode #(
      .CMP_N (CMP_N),
      .DIG_W (DIG_W)
   ) dec_i (
      .therm (code_use),
      .digit (digit),
      .bad   (code_bad)
   );

   // decided digits, MSB first, lower bits zero
   logic [RES_BITS-1:0] acc_q;
   logic [RES_BITS-1:0] acc_next;
   logic                err_q;
   logic                err_next;

   always_comb begin
      int shamt;
      shamt    = (NUM_STEPS - 1 - int'(step_idx)) * DIG_W;
      acc_next = acc_q | (RES_BITS'(digit) << shamt);
      err_next = err_q | code_bad;
   end

   sar2_tap_calc #(
      .RES_BITS (RES_BITS),
      .STEP_W   (STEP_W),
      .TAP_W    (TAP_W)
   ) tap_i (
      .en     (in_step),
      .base   (acc_q),
      .step   (step_idx),
      .tap_lo (tap_lo),
      .tap_hi (tap_hi)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_q    <= '0;
         acc_q    <= '0;
         err_q    <= 1'b0;
         done     <= 1'b0;
         result   <= '0;
         code_err <= 1'b0;
      end else begin
         done <= conv_end;

         if (!in_step || step_last) begin
            cap_q <= '0;
         end else if (cmp_valid) begin
            cap_q <= cmp_therm;
         end

         if (go) begin
            acc_q <= '0;
            err_q <= 1'b0;
         end else if (step_last) begin
            acc_q <= acc_next;
            err_q <= err_next;
         end

         if (conv_end) begin
            result   <= acc_next;
            code_err <= err_next;
         end
      end
   end

endmodule

// File: rtl/sar2_ctrl_chk.sv
module sar2_ctrl_chk #(
   parameter int RES_BITS  = 8,
   parameter int NUM_STEPS = 4,
   parameter int TAP_W     = RES_BITS - 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic                 sampling,
   input logic [NUM_STEPS-1:0] step_phase,
   input logic [TAP_W-1:0]     tap_lo,
   input logic [TAP_W-1:0]     tap_hi,
   input logic                 done
);

   localparam int QTR      = 1 << (RES_BITS - 2);
   localparam int FIRST_LO = (QTR - 1) / 2;
   localparam int FIRST_HI = (3 * QTR - 1) / 2;

   p_phase_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sampling, step_phase}));

   p_sample_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sampling |=> (sampling || step_phase[0]));

   p_taps_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_phase == '0) |-> (tap_lo == '0 && tap_hi == '0));

   p_first_taps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step_phase[0] |-> (tap_lo == TAP_W'(FIRST_LO) && tap_hi == TAP_W'(FIRST_HI)));

   p_hi_above_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_phase != '0) |-> (tap_hi > tap_lo));

   p_last_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      step_phase[NUM_STEPS-1] |-> (tap_hi == tap_lo + TAP_W'(1)));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(step_phase[NUM_STEPS-1]));

   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (step_phase[0] && start) |=> !sampling);

endmodule

bind sar2_ctrl sar2_ctrl_chk #(
   .RES_BITS  (RES_BITS),
   .NUM_STEPS (NUM_STEPS),
   .TAP_W     (TAP_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .sampling   (sampling),
   .step_phase (step_phase),
   .tap_lo     (tap_lo),
   .tap_hi     (tap_hi),
   .done       (done)
);

// File: tb/sar2_ctrl_tb_top.sv
module sar2_ctrl_tb_top;

   localparam int S  = 2;
   localparam int T  = 3;
   localparam int NV = 8;
   localparam int LAST_I = S + 4 * T + 1;

   // per vector: step0..step3 codes (3 bits each, step0 in the top bits)
   localparam logic [11:0] VCODE [NV] = '{
      12'b000_000_000_000, 12'b111_111_111_111,
      12'b001_011_111_000, 12'b011_001_000_111,
      12'b010_111_000_000, 12'b101_110_100_011,
      12'b000_111_001_011, 12'b111_000_011_001
   };
   // {error flag, result}
   localparam logic [8:0] VEXP [NV] = '{
      {1'b0, 8'h00}, {1'b0, 8'hFF}, {1'b0, 8'h6C}, {1'b0, 8'h93},
      {1'b1, 8'h70}, {1'b1, 8'hA6}, {1'b0, 8'h36}, {1'b0, 8'hC9}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       cmp_valid = 1'b0;
   logic [2:0] cmp_therm = 3'b000;
   logic       sampling;
   logic [3:0] step_phase;
   logic [6:0] tap_lo;
   logic [6:0] tap_hi;
   logic       done;
   logic [7:0] result;
   logic       code_err;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   sar2_ctrl #(
      .RES_BITS      (8),
      .SAMPLE_CYCLES (S),
      .STEP_CYCLES   (T)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cmp_valid  (cmp_valid),
      .cmp_therm  (cmp_therm),
      .sampling   (sampling),
      .step_phase (step_phase),
      .tap_lo     (tap_lo),
      .tap_hi     (tap_hi),
      .done       (done),
      .result     (result),
      .code_err   (code_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_conv(input logic [11:0] codes, input logic [3:0] vmask,
                           input bit mid_start, input logic [7:0] exp_res,
                           input bit exp_err);
      int  base;
      bit  ph_ok;
      int  first_bad;
      logic [7:0] held;
      base      = 0;
      ph_ok     = 1'b1;
      first_bad = 0;
      held      = 8'h00;
      @(negedge clk);
      start = 1'b1;
      for (int i = 1; i <= LAST_I + 2; i++) begin
         int kk;
         logic [3:0] exp_ph;
         @(negedge clk);
         start     = 1'b0;
         cmp_valid = 1'b0;
         cmp_therm = 3'b111;
         kk     = (i > S && i <= S + 4 * T) ? (i - S - 1) / T : -1;
         exp_ph = (kk >= 0) ? 4'(1 << kk) : 4'b0000;
         if (sampling !== (i <= S) || step_phase !== exp_ph || done !== (i == LAST_I)) begin
            if (ph_ok) first_bad = i;
            ph_ok = 1'b0;
         end
         if (kk >= 0 && ((i - S - 1) % T) == 0) begin
            int q;
            logic [2:0] c;
            q = 64 >> (2 * kk);
            chk(int'(tap_lo) == ((base + q - 1) >> 1), (kk == 0) ? "R3 tap_lo" : "R4 tap_lo",
                int'(tap_lo), (base + q - 1) >> 1);
            chk(int'(tap_hi) == ((base + 3 * q - 1) >> 1), (kk == 0) ? "R3 tap_hi" : "R4 tap_hi",
                int'(tap_hi), (base + 3 * q - 1) >> 1);
            if (kk == 3) chk(tap_hi == tap_lo + 7'd1, "R5 last gap", int'(tap_hi), int'(tap_lo) + 1);
            c = codes[11 - 3 * kk -: 3];
            if (vmask[kk]) begin
               cmp_valid = 1'b1;
               cmp_therm = c;
               base      = base + $countones(c) * q;
            end
         end
         if (mid_start && i == S + 2) start = 1'b1;
         if (i == LAST_I) begin
            chk(result == exp_res, "R6 result", int'(result), int'(exp_res));
            chk(code_err == exp_err, "R7 code_err", int'(code_err), int'(exp_err));
            held = result;
         end
         if (i > LAST_I) begin
            chk(tap_lo == 7'd0 && tap_hi == 7'd0, "R2 taps idle", int'({tap_hi, tap_lo}), 0);
            chk(result == held, "R9 result held", int'(result), int'(held));
         end
      end
      chk(ph_ok, mid_start ? "R10 phases with late start" : "R1 phase sequence", first_bad, 0);
   endtask

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state, R2 taps zero
      chk(done == 1'b0 && result == 8'h00 && code_err == 1'b0, "R11 reset outputs",
          int'({done, code_err, result}), 0);
      chk(sampling == 1'b0 && step_phase == 4'b0000, "R11 reset phases", int'({sampling, step_phase}), 0);
      chk(tap_lo == 7'd0 && tap_hi == 7'd0, "R2 taps in reset", int'({tap_hi, tap_lo}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         run_conv(VCODE[v], 4'b1111, 1'b0, VEXP[v][7:0], VEXP[v][8]);
      end

      // R8: steps 0 and 2 have no valid strobe while cmp_therm shows 111
      run_conv(12'b111_111_111_111, 4'b1010, 1'b0, 8'h33, 1'b0);

      // R10: a second start during step 0
      run_conv(12'b010_111_000_000, 4'b1111, 1'b1, 8'h70, 1'b1);

      // R11: reset in the middle of step 1 after a nonzero result with error
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (S + T) @(negedge clk);
      chk(step_phase == 4'b0010, "R11 precondition step 1", int'(step_phase), 2);
      rst_n = 1'b0;
      @(negedge clk);
      chk(result == 8'h00 && code_err == 1'b0 && done == 1'b0, "R11 mid reset outputs",
          int'({done, code_err, result}), 0);
      chk(sampling == 1'b0 && step_phase == 4'b0000 && tap_lo == 7'd0 && tap_hi == 7'd0,
          "R11 mid reset phases", int'({sampling, step_phase}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_conv(VCODE[2], 4'b1111, 1'b0, VEXP[2][7:0], VEXP[2][8]);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule